// File: doc/BRIEF.md
# ADC Power-Up and Identification Sequencer

This block brings a multi-channel biopotential ADC out of power-up and into a known state. After reset it holds the converter's hardware reset pin for a minimum number of device clocks and then releases it. It sends a soft reset command and waits for the settling time. It then sends a command that leaves the streaming read mode the converter powers up in, and reads the identification register. The ID value gives the family and the channel count. Last, it programs the test-signal register and the reference register.

The block sends no serial traffic of its own. Each command, register read and register write is handed to a separate SPI register engine through a request/acknowledge pair. The device clock is not a separate clock. Its period is counted as a fixed number of system clocks, set by a parameter, and every wait is measured in those device periods. When the sequence completes, the block reports the channel count and the family, and then raises a done flag. An unrecognised ID raises an error flag and stops the sequence. A start pulse restarts the whole sequence at any time.

Top module: `afe_boot_seq`

## Requirements
- R1: After reset or a start pulse, dev_rst_o is high for at least HOLD_TICKS device periods (DEV_CLK_DIV system clocks each), and no request is presented while it is high.
- R2: The first request after the hold is a command (req_op_o = 0) with byte 0x06. After its acknowledge, no request is presented for at least SETTLE_TICKS device periods.
- R3: The second request is a command with byte 0x11.
- R4: The third request is a register read (req_op_o = 1) of address 0x00. The upper five ID bits select the family: 0b10010 (ID & 0xF8 = 0x90) gives family_ext_o = 0, and 0b11010 (0xD0) gives family_ext_o = 1.
- R5: chan_count_o equals 4 + 2 × ID[2:0] once done_o is high.
- R6: If the upper ID bits match neither family, id_err_o goes high, done_o stays low and no further request is presented until the next start pulse.
- R7: The fourth request is a register write (req_op_o = 2) of value 0x55 to address 0x02.
- R8: The fifth request writes address 0x03. Bit 6 is always set. Bit 7 is set when ext_ref_i is low. Bit 5 is set when ext_ref_i is low and supply_hi_i is high. The flags are sampled while dev_rst_o is high.
- R9: done_o is low until the write to 0x03 is acknowledged. It rises at that acknowledging clock edge and stays high until the next start.
- R10: A presented request keeps req_op_o, req_addr_o and req_data_o stable until req_ack_i, and only one request is outstanding at a time.
- R11: A start pulse in any state, including mid-sequence, clears done_o and id_err_o, raises dev_rst_o at the next edge and repeats the sequence from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Restart pulse |
| ext_ref_i | input | 1 | External reference is fitted |
| supply_hi_i | input | 1 | Analog supply is at least 4.4 V |
| dev_rst_o | output | 1 | Converter hardware reset, active high |
| req_valid_o | output | 1 | Request presented to the register engine |
| req_op_o | output | 2 | 0 command, 1 register read, 2 register write |
| req_addr_o | output | 8 | Register address for read/write |
| req_data_o | output | 8 | Command byte or write value |
| req_ack_i | input | 1 | One-cycle pulse: request finished |
| rsp_data_i | input | 8 | Read data, valid with req_ack_i |
| chan_count_o | output | 5 | Decoded channel count |
| family_ext_o | output | 1 | Extended family detected |
| done_o | output | 1 | Sequence complete |
| id_err_o | output | 1 | Unknown ID, sequence halted |

## Verification
Every output is registered from the next state, so a change appears at the same edge at which the state moves. The request after an acknowledge, the rise of done_o and the rise of dev_rst_o after a start therefore all appear one edge after the stimulus is sampled. The hold and settle windows run for the programmed number of device periods plus one system cycle. The bench drives and samples on the falling edge. It counts falling edges in the reset window and in the idle gap after the reset command, and accepts a count of one system cycle below to two above the programmed length, which absorbs the sampling offset. It samples done_o before each final acknowledge and again at the first falling edge after it.

// File: rtl/afe_boot_pkg.sv
package afe_boot_pkg;

  typedef enum logic [1:0] {
    OP_CMD = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } req_op_t;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_CMD_RST,
    ST_WAIT,
    ST_CMD_HALT,
    ST_RD_ID,
    ST_WR_TEST,
    ST_WR_REF,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  localparam logic [7:0] CMD_SOFT_RESET  = 8'h06;
  localparam logic [7:0] CMD_HALT_STREAM = 8'h11;
  localparam logic [7:0] REG_IDENT       = 8'h00;
  localparam logic [7:0] REG_TESTCFG     = 8'h02;
  localparam logic [7:0] REG_REFCFG      = 8'h03;
  localparam logic [7:0] TESTCFG_VAL     = 8'h55;

  localparam logic [4:0] FAM_BASE = 5'b10010;
  localparam logic [4:0] FAM_EXT  = 5'b11010;

  // Reference register: bit 6 fixed, bit 7 buffer power, bit 5 high reference
  function automatic logic [7:0] ref_cfg(input logic ext_ref, input logic supply_hi);
    logic [7:0] v;
    v = 8'h40;
    if (!ext_ref) begin
      v[7] = 1'b1;
      v[5] = supply_hi;
    end
    return v;
  endfunction

endpackage

// File: rtl/afe_boot_tick.sv
module afe_boot_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = ~clr;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || clr)          cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end
      assign tick = !clr && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/afe_boot_timer.sv
module afe_boot_timer #(
  parameter int MAXT = 18,
  parameter int TW   = $clog2(MAXT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] target,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)                   cnt_q <= '0;
    else if (tick && cnt_q != target) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == target);
endmodule

// File: rtl/afe_boot_id_dec.sv
module afe_boot_id_dec
  import afe_boot_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [7:0]    id_i,
  output logic          known_o,
  output logic          ext_o,
  output logic [CW-1:0] count_o
);
  always_comb begin
    ext_o   = (id_i[7:3] == FAM_EXT);
    known_o = ext_o || (id_i[7:3] == FAM_BASE);
    count_o = CW'(4) + CW'({id_i[2:0], 1'b0});
  end
endmodule

// File: rtl/afe_boot_seq.sv
module afe_boot_seq
  import afe_boot_pkg::*;
#(
  parameter int DEV_CLK_DIV  = 4,
  parameter int HOLD_TICKS   = 2,
  parameter int SETTLE_TICKS = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       ext_ref_i,
  input  logic       supply_hi_i,
  output logic       dev_rst_o,
  output logic       req_valid_o,
  output logic [1:0] req_op_o,
  output logic [7:0] req_addr_o,
  output logic [7:0] req_data_o,
  input  logic       req_ack_i,
  input  logic [7:0] rsp_data_i,
  output logic [4:0] chan_count_o,
  output logic       family_ext_o,
  output logic       done_o,
  output logic       id_err_o
);
  localparam int MAX_TICKS = (HOLD_TICKS > SETTLE_TICKS) ? HOLD_TICKS : SETTLE_TICKS;
  localparam int TW        = $clog2(MAX_TICKS + 1);
  localparam int CKW       = $clog2((MAX_TICKS + 1) * DEV_CLK_DIV + 1) + 1;

  seq_state_t    state_q, state_d;
  logic          tick, expired, tmr_clr;
  logic [TW-1:0] target;
  logic          id_known, id_ext;
  logic [4:0]    id_count;
  logic [7:0]    ref_cfg_q;

  assign tmr_clr = start_i || !(state_q == ST_HOLD || state_q == ST_WAIT);
  assign target  = (state_q == ST_HOLD) ? TW'(HOLD_TICKS) : TW'(SETTLE_TICKS);

  afe_boot_tick #(.DIV(DEV_CLK_DIV)) i_tick (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick)
  );

  afe_boot_timer #(.MAXT(MAX_TICKS), .TW(TW)) i_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick),
    .target(target), .expired(expired)
  );

  afe_boot_id_dec #(.CW(5)) i_id_dec (
    .id_i(rsp_data_i), .known_o(id_known), .ext_o(id_ext), .count_o(id_count)
  );

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_HOLD;
    end else begin
      case (state_q)
        ST_HOLD:     if (expired)   state_d = ST_CMD_RST;
        ST_CMD_RST:  if (req_ack_i) state_d = ST_WAIT;
        ST_WAIT:     if (expired)   state_d = ST_CMD_HALT;
        ST_CMD_HALT: if (req_ack_i) state_d = ST_RD_ID;
        ST_RD_ID:    if (req_ack_i) state_d = id_known ? ST_WR_TEST : ST_FAIL;
        ST_WR_TEST:  if (req_ack_i) state_d = ST_WR_REF;
        ST_WR_REF:   if (req_ack_i) state_d = ST_DONE;
        ST_DONE:     state_d = ST_DONE;
        ST_FAIL:     state_d = ST_FAIL;
        default:     state_d = ST_HOLD;
      endcase
    end
  end

  function automatic logic is_req(input seq_state_t s);
    return (s == ST_CMD_RST) || (s == ST_CMD_HALT) || (s == ST_RD_ID) ||
           (s == ST_WR_TEST) || (s == ST_WR_REF);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_HOLD;
      dev_rst_o    <= 1'b1;
      req_valid_o  <= 1'b0;
      req_op_o     <= OP_CMD;
      req_addr_o   <= '0;
      req_data_o   <= '0;
      done_o       <= 1'b0;
      id_err_o     <= 1'b0;
      chan_count_o <= '0;
      family_ext_o <= 1'b0;
      ref_cfg_q    <= 8'h40;
    end else begin
      state_q     <= state_d;
      dev_rst_o   <= (state_d == ST_HOLD);
      req_valid_o <= is_req(state_d);
      done_o      <= (state_d == ST_DONE);
      id_err_o    <= (state_d == ST_FAIL);
      if (state_q == ST_HOLD) ref_cfg_q <= ref_cfg(ext_ref_i, supply_hi_i);
      case (state_d)
        ST_CMD_RST:  begin req_op_o <= OP_CMD; req_addr_o <= '0;          req_data_o <= CMD_SOFT_RESET;  end
        ST_CMD_HALT: begin req_op_o <= OP_CMD; req_addr_o <= '0;          req_data_o <= CMD_HALT_STREAM; end
        ST_RD_ID:    begin req_op_o <= OP_RD;  req_addr_o <= REG_IDENT;   req_data_o <= '0;              end
        ST_WR_TEST:  begin req_op_o <= OP_WR;  req_addr_o <= REG_TESTCFG; req_data_o <= TESTCFG_VAL;     end
        ST_WR_REF:   begin req_op_o <= OP_WR;  req_addr_o <= REG_REFCFG;  req_data_o <= ref_cfg_q;       end
        default:     begin req_op_o <= OP_CMD; req_addr_o <= '0;          req_data_o <= '0;              end
      endcase
      if (start_i) begin
        chan_count_o <= '0;
        family_ext_o <= 1'b0;
      end else if (state_q == ST_RD_ID && req_ack_i && id_known) begin
        chan_count_o <= id_count;
        family_ext_o <= id_ext;
      end
    end
  end

  // Window counters used only by the checks below
  logic [CKW-1:0] hold_cnt_q, idle_cnt_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt_q <= '0;
      idle_cnt_q <= '0;
    end else begin
      hold_cnt_q <= !dev_rst_o ? '0 : (&hold_cnt_q ? hold_cnt_q : hold_cnt_q + 1'b1);
      idle_cnt_q <= req_valid_o ? '0 : (&idle_cnt_q ? idle_cnt_q : idle_cnt_q + 1'b1);
    end
  end

  assert_hold_len_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(dev_rst_o) |-> hold_cnt_q >= CKW'(HOLD_TICKS * DEV_CLK_DIV));

  assert_quiet_in_reset_R1: assert property (@(posedge clk) disable iff (rst)
    dev_rst_o |-> !req_valid_o);

  assert_settle_gap_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid_o) && req_op_o == OP_CMD && req_data_o == CMD_HALT_STREAM)
      |-> idle_cnt_q >= CKW'(SETTLE_TICKS * DEV_CLK_DIV));

  assert_count_form_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (chan_count_o[0] == 1'b0 && chan_count_o >= 5'd4 && chan_count_o <= 5'd18));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (id_err_o && !start_i) |=> (id_err_o && !req_valid_o && !done_o));

  assert_done_on_ack_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(req_ack_i));

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ack_i && !start_i) |=>
      (req_valid_o && $stable(req_op_o) && $stable(req_addr_o) && $stable(req_data_o)));

  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (dev_rst_o && !done_o && !id_err_o));

endmodule

// File: tb/test_afe_boot_seq.sv
`timescale 1ns/1ps
module test_afe_boot_seq;
  localparam int DIV    = 4;
  localparam int HOLD   = 2;
  localparam int SETTLE = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       ext_ref_i = 1'b0;
  logic       supply_hi_i = 1'b0;
  logic       dev_rst_o, req_valid_o, family_ext_o, done_o, id_err_o;
  logic [1:0] req_op_o;
  logic [7:0] req_addr_o, req_data_o;
  logic       req_ack_i = 1'b0;
  logic [7:0] rsp_data_i = 8'h00;
  logic [4:0] chan_count_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int t_op[8], t_addr[8], t_data[8];
  int n_txn, rst_cyc, gap_cyc;
  bit done_before_last;

  always #4 clk = ~clk;

  afe_boot_seq #(.DEV_CLK_DIV(DIV), .HOLD_TICKS(HOLD), .SETTLE_TICKS(SETTLE)) i_afe_boot_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .ext_ref_i(ext_ref_i),
    .supply_hi_i(supply_hi_i), .dev_rst_o(dev_rst_o), .req_valid_o(req_valid_o),
    .req_op_o(req_op_o), .req_addr_o(req_addr_o), .req_data_o(req_data_o),
    .req_ack_i(req_ack_i), .rsp_data_i(rsp_data_i), .chan_count_o(chan_count_o),
    .family_ext_o(family_ext_o), .done_o(done_o), .id_err_o(id_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // Register engine model: serves requests, records them, measures windows
  task automatic serve(input logic [7:0] id, input int max_txn);
    int guard;
    n_txn = 0; rst_cyc = 0; gap_cyc = 0; guard = 0; done_before_last = 0;
    rsp_data_i = id;
    while (n_txn < max_txn && !done_o && !id_err_o && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (dev_rst_o) rst_cyc++;
      if (n_txn == 1 && !req_valid_o) gap_cyc++;
      if (req_valid_o) begin
        t_op[n_txn] = int'(req_op_o); t_addr[n_txn] = int'(req_addr_o); t_data[n_txn] = int'(req_data_o);
        repeat (2) @(negedge clk);
        if (n_txn == 4) done_before_last = done_o;
        req_ack_i = 1'b1;
        @(negedge clk);
        req_ack_i = 1'b0;
        n_txn++;
      end
    end
  endtask

  task automatic check_windows();
    chk(rst_cyc >= 2*DIV-1 && rst_cyc <= 2*DIV+2, "R1", "reset hold cycles", rst_cyc, HOLD*DIV);
    chk(gap_cyc >= SETTLE*DIV-1 && gap_cyc <= SETTLE*DIV+2, "R2", "settle gap cycles", gap_cyc, SETTLE*DIV);
    chk(t_op[0] == 0 && t_data[0] == 8'h06, "R2", "first request", t_data[0], 8'h06);
    chk(t_op[1] == 0 && t_data[1] == 8'h11, "R3", "second request", t_data[1], 8'h11);
    chk(t_op[2] == 1 && t_addr[2] == 8'h00, "R4", "id read op", t_op[2], 1);
  endtask

  task automatic check_full(input int exp_ch, input bit exp_ext, input int exp_cfg);
    check_windows();
    chk(n_txn == 5, "R10", "request count", n_txn, 5);
    chk(t_op[3] == 2 && t_addr[3] == 8'h02 && t_data[3] == 8'h55, "R7", "test cfg write", t_data[3], 8'h55);
    chk(t_op[4] == 2 && t_addr[4] == 8'h03, "R8", "ref cfg address", t_addr[4], 8'h03);
    chk(t_data[4] == exp_cfg, "R8", "ref cfg value", t_data[4], exp_cfg);
    chk(done_before_last == 1'b0, "R9", "done early", int'(done_before_last), 0);
    chk(done_o == 1'b1 && id_err_o == 1'b0, "R9", "done after final ack", int'(done_o), 1);
    chk(int'(chan_count_o) == exp_ch, "R5", "channel count", int'(chan_count_o), exp_ch);
    chk(family_ext_o == exp_ext, "R4", "family flag", int'(family_ext_o), int'(exp_ext));
  endtask

  task automatic test_reset_state();
    chk(dev_rst_o == 1'b1, "R1", "dev reset during rst", int'(dev_rst_o), 1);
    chk(req_valid_o == 1'b0 && done_o == 1'b0 && id_err_o == 1'b0, "R1", "idle outputs in rst",
        int'({req_valid_o, done_o, id_err_o}), 0);
  endtask

  task automatic test_ext_family_high_supply();
    ext_ref_i = 1'b0; supply_hi_i = 1'b1;
    pulse_start();
    serve(8'hD3, 8);
    check_full(10, 1'b1, 8'hE0);
  endtask

  task automatic test_base_family_low_supply();
    ext_ref_i = 1'b0; supply_hi_i = 1'b0;
    pulse_start();
    chk(done_o == 1'b0 && dev_rst_o == 1'b1, "R11", "start clears done", int'(done_o), 0);
    serve(8'h96, 8);
    check_full(16, 1'b0, 8'hC0);
  endtask

  task automatic test_external_ref();
    ext_ref_i = 1'b1; supply_hi_i = 1'b1;
    pulse_start();
    serve(8'h90, 8);
    check_full(4, 1'b0, 8'h40);
  endtask

  task automatic test_unknown_id();
    int seen;
    ext_ref_i = 1'b0; supply_hi_i = 1'b1;
    pulse_start();
    serve(8'hA5, 8);
    check_windows();
    chk(id_err_o == 1'b1, "R6", "error flag", int'(id_err_o), 1);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (req_valid_o || done_o) seen++;
    end
    chk(seen == 0, "R6", "activity after bad id", seen, 0);
    pulse_start();
    chk(id_err_o == 1'b0, "R11", "start clears error", int'(id_err_o), 0);
    serve(8'hD7, 8);
    check_full(18, 1'b1, 8'hE0);
  endtask

  task automatic test_mid_restart();
    ext_ref_i = 1'b0; supply_hi_i = 1'b1;
    pulse_start();
    serve(8'h92, 1);
    repeat (10) @(negedge clk);
    chk(req_valid_o == 1'b0 && dev_rst_o == 1'b0, "R2", "quiet in settle", int'(req_valid_o), 0);
    pulse_start();
    chk(dev_rst_o == 1'b1, "R11", "mid restart reasserts reset", int'(dev_rst_o), 1);
    serve(8'h92, 8);
    check_full(8, 1'b0, 8'hE0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_state();
    @(negedge clk); rst = 1'b0;
    test_ext_family_high_supply();
    test_base_family_low_supply();
    test_external_ref();
    test_unknown_id();
    test_mid_restart();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule